// File: doc/BRIEF.md
# Command/Response FIFO Status Engine

This block sits on the device side of a byte-wide command/response port. It holds the status register, the two-byte burst-count field and the data FIFO. A host pushes command bytes through the FIFO offset. The engine finds the total command length, which is a big-endian 32-bit value in bytes 2 to 5 of a 10-byte header, and raises the data-expect flag until that many bytes have arrived. A go write then starts a backend. The backend fetches the command through a read port, writes its response bytes back, and ends with a done strobe. The host drains the response through the same FIFO offset, steered by the data-available flag and the burst count.

The command and the response share one byte buffer of `DEPTH` entries, because they are never live at the same time. A write with the command-ready bit set abandons whatever is in flight and returns the engine to its ready state. The backend sees this as its request line dropping.

Top module: `cmd_rsp_fifo_engine`

## Requirements
- R1: After reset the status byte (offset 0x18) reads 0xC0, the burst count reads DEPTH, `exec_req` is low, and a FIFO read returns 0xFF.
- R2: Status byte layout: bit 7 is always 1, bit 6 is set only in the ready state, bit 5 always reads 0, bit 4 is data-available, bit 3 is data-expect, and bits 2..0 read 0. Burst low byte is at 0x19, burst high byte at 0x1A, the FIFO at 0x24, and any other offset reads 0xFF.
- R3: The first FIFO write starts reception. Data-expect stays 1 until the number of bytes written equals the target length, then goes to 0. The target is the big-endian value in command bytes 2..5, raised to 10 if smaller and lowered to DEPTH if larger.
- R4: During reception the burst count equals DEPTH minus the bytes accepted so far. FIFO writes after the target is reached are ignored and leave the burst count unchanged.
- R5: A write of status bit 5 (go) with a complete command raises `exec_req` on the next clock. `cmd_len` then equals the target, and `cmd_rd_data` returns the byte at `cmd_rd_addr`. Go with an incomplete command is ignored, and data-expect stays 1.
- R6: While `exec_req` is high, each `rsp_wr` stores `rsp_byte` at the next buffer position. `rsp_done` ends execution. The response length is the number of bytes written, limited to the clamped header value once 6 bytes are in. Data-available is then 1 and the burst count equals that length. A byte offered in the same cycle as `rsp_done` is dropped.
- R7: FIFO reads return the response bytes in order, and each read lowers the burst count by one. Data-available clears after the last byte.
- R8: A FIFO read outside completion, or after the response is used up, returns 0xFF and changes nothing. A FIFO write during execution or completion is ignored.
- R9: A status write with bit 6 set returns the engine to ready from any state, with status 0xC0, burst DEPTH and `exec_req` low. This takes priority over bit 5 in the same write.
- R10: `rsp_wr` outside execution is ignored. The response bytes and the burst count stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Host register write strobe |
| bus_rd | input | 1 | Host register read strobe (FIFO read has side effect) |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, combinational from offset and state |
| exec_req | output | 1 | High while the backend owns the command |
| cmd_len | output | CW | Command byte count |
| cmd_rd_addr | input | AW | Backend command read index |
| cmd_rd_data | output | 8 | Backend command read byte |
| rsp_wr | input | 1 | Backend response byte strobe |
| rsp_byte | input | 8 | Backend response byte |
| rsp_done | input | 1 | Backend end-of-response strobe |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high in the same cycle. They also assume that the backend raises `rsp_wr` and `rsp_done` only in response to `exec_req` and never with both in one cycle. The bench drives one host operation per clock, separated by idle cycles. The backend model it contains answers only while `exec_req` is high, except for deliberate stray response strobes in completion and ready. The random part draws command and response lengths below, inside and above the legal window, so the clamping paths are exercised.

// File: rtl/cfe_pkg.sv
// Shared constants and types for the command/response FIFO engine.
// Assumes byte-wide host access and a 10-byte header with a 32-bit length.
package cfe_pkg;

    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_RECV  = 2'd1,
        ST_EXEC  = 2'd2,
        ST_DONE  = 2'd3
    } eng_state_t;

    localparam int HDR_BYTES = 10;
    localparam int LEN_FIRST = 2;
    localparam int LEN_LAST  = 5;

    localparam logic [7:0] OFS_STS      = 8'h18;
    localparam logic [7:0] OFS_BURST_LO = 8'h19;
    localparam logic [7:0] OFS_BURST_HI = 8'h1A;
    localparam logic [7:0] OFS_FIFO     = 8'h24;
    localparam logic [7:0] IDLE_BYTE    = 8'hFF;

    localparam int BIT_VALID  = 7;
    localparam int BIT_READY  = 6;
    localparam int BIT_GO     = 5;
    localparam int BIT_AVAIL  = 4;
    localparam int BIT_EXPECT = 3;

endpackage

// File: rtl/cfe_byte_store.sv
// Byte buffer shared by the command and the response.
// One write port and two asynchronous read ports; contents are not reset.
module cfe_byte_store #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [7:0]    wr_byte,
    input  logic [AW-1:0] rd_a_idx,
    output logic [7:0]    rd_a_byte,
    input  logic [AW-1:0] rd_b_idx,
    output logic [7:0]    rd_b_byte
);

    logic [7:0] cells [DEPTH];

    // Store one byte per accepted write.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_idx] <= wr_byte;
        end
    end

    // Read ports for the backend (a) and the host (b).
    always_comb begin
        rd_a_byte = cells[rd_a_idx];
        rd_b_byte = cells[rd_b_idx];
    end

endmodule

// File: rtl/cfe_len_tracker.sv
// Watches a byte stream by position and collects the big-endian length
// in header bytes 2..5, then clamps it into [HDR_BYTES, DEPTH].
// Assumes positions arrive in increasing order from 0 after each clear.
module cfe_len_tracker
    import cfe_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic [CW-1:0] idx,
    input  logic [7:0]    byte_in,
    output logic          hdr_seen,
    output logic [CW-1:0] target
);

    logic [31:0] raw_len;
    logic        in_field;

    assign in_field = (idx >= CW'(LEN_FIRST)) && (idx <= CW'(LEN_LAST));

    // Shift length bytes in, most significant first.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            raw_len  <= '0;
            hdr_seen <= 1'b0;
        end else if (push) begin
            if (in_field) begin
                raw_len <= {raw_len[23:0], byte_in};
            end
            if (idx == CW'(LEN_LAST)) begin
                hdr_seen <= 1'b1;
            end
        end
    end

    // Clamp the declared length into the legal window.
    always_comb begin
        if (raw_len < 32'(HDR_BYTES)) begin
            target = CW'(HDR_BYTES);
        end else if (raw_len > 32'(DEPTH)) begin
            target = CW'(DEPTH);
        end else begin
            target = raw_len[CW-1:0];
        end
    end

endmodule

// File: rtl/cfe_ctrl.sv
// Phase controller: ready, reception, execution, completion.
// Owns the write, response and read counters and derives the flags and
// the burst count. Assumes abort and go come from one status write.
module cfe_ctrl
    import cfe_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          abort,
    input  logic          go,
    input  logic          host_wr_fifo,
    input  logic          host_rd_fifo,
    input  logic          rsp_wr,
    input  logic          rsp_done,
    input  logic          cmd_hdr_seen,
    input  logic [CW-1:0] cmd_target,
    input  logic          rsp_hdr_seen,
    input  logic [CW-1:0] rsp_target,
    output eng_state_t    state,
    output logic [CW-1:0] wcnt,
    output logic [CW-1:0] rwcnt,
    output logic [CW-1:0] rd_ptr,
    output logic [CW-1:0] rsp_len,
    output logic          cmd_push,
    output logic          rsp_push,
    output logic          go_ok,
    output logic          expect_flag,
    output logic          avail_flag,
    output logic [15:0]   burst
);

    logic [CW-1:0] wr_limit;
    logic          cmd_complete;
    logic          rd_adv;
    logic [CW-1:0] rsp_eff;

    // Acceptance conditions for host and backend traffic.
    always_comb begin
        wr_limit     = cmd_hdr_seen ? cmd_target : CW'(DEPTH);
        cmd_complete = (state == ST_RECV) && cmd_hdr_seen && (wcnt == cmd_target);
        cmd_push     = !abort && host_wr_fifo &&
                       ((state == ST_READY) || ((state == ST_RECV) && (wcnt < wr_limit)));
        go_ok        = go && !abort && cmd_complete;
        rsp_push     = !abort && rsp_wr && !rsp_done &&
                       (state == ST_EXEC) && (rwcnt < CW'(DEPTH));
        rd_adv       = !abort && host_rd_fifo && (state == ST_DONE) && (rd_ptr < rsp_len);
        rsp_eff      = (rsp_hdr_seen && (rsp_target < rwcnt)) ? rsp_target : rwcnt;
    end

    // Phase and counter update; abort wins over everything else.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            state   <= ST_READY;
            wcnt    <= '0;
            rwcnt   <= '0;
            rd_ptr  <= '0;
            rsp_len <= '0;
        end else begin
            case (state)
                ST_READY: begin
                    if (cmd_push) begin
                        state <= ST_RECV;
                        wcnt  <= CW'(1);
                    end
                end
                ST_RECV: begin
                    if (go_ok) begin
                        state <= ST_EXEC;
                        rwcnt <= '0;
                    end else if (cmd_push) begin
                        wcnt <= wcnt + CW'(1);
                    end
                end
                ST_EXEC: begin
                    if (rsp_done) begin
                        state   <= ST_DONE;
                        rsp_len <= rsp_eff;
                        rd_ptr  <= '0;
                    end else if (rsp_push) begin
                        rwcnt <= rwcnt + CW'(1);
                    end
                end
                ST_DONE: begin
                    if (rd_adv) begin
                        rd_ptr <= rd_ptr + CW'(1);
                    end
                end
                default: state <= ST_READY;
            endcase
        end
    end

    // Status flags and burst count seen by the host.
    always_comb begin
        expect_flag = (state == ST_RECV) && !cmd_complete;
        avail_flag  = (state == ST_DONE) && (rd_ptr < rsp_len);
        case (state)
            ST_READY: burst = 16'(DEPTH);
            ST_RECV:  burst = 16'(DEPTH) - 16'(wcnt);
            ST_DONE:  burst = 16'(rsp_len) - 16'(rd_ptr);
            default:  burst = 16'd0;
        endcase
    end

endmodule

// File: rtl/cmd_rsp_fifo_engine.sv
// Top of the command/response FIFO engine: decodes host register accesses,
// wires the controller, both length trackers and the shared byte buffer,
// and forms the read data. Assumes DEPTH is between 10 and 65535.
module cmd_rsp_fifo_engine
    import cfe_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [7:0]    bus_addr,
    input  logic [7:0]    bus_wdata,
    output logic [7:0]    bus_rdata,
    output logic          exec_req,
    output logic [CW-1:0] cmd_len,
    input  logic [AW-1:0] cmd_rd_addr,
    output logic [7:0]    cmd_rd_data,
    input  logic          rsp_wr,
    input  logic [7:0]    rsp_byte,
    input  logic          rsp_done
);

    logic          sts_wr, abort, go, host_wr_fifo, host_rd_fifo;
    eng_state_t    cur_state;
    logic [CW-1:0] wcnt, rwcnt, rd_ptr, rsp_len;
    logic          cmd_push, rsp_push, go_ok, expect_flag, avail_flag;
    logic [15:0]   burst;
    logic          cmd_hdr_seen, rsp_hdr_seen;
    logic [CW-1:0] cmd_target, rsp_target;
    logic          st_wr_en;
    logic [AW-1:0] st_wr_idx;
    logic [7:0]    st_wr_byte, host_byte;
    logic [7:0]    status_byte;

    // Host access decode.
    always_comb begin
        sts_wr       = bus_wr && (bus_addr == OFS_STS);
        abort        = sts_wr && bus_wdata[BIT_READY];
        go           = sts_wr && bus_wdata[BIT_GO];
        host_wr_fifo = bus_wr && (bus_addr == OFS_FIFO);
        host_rd_fifo = bus_rd && !bus_wr && (bus_addr == OFS_FIFO);
    end

    cfe_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .abort        (abort),
        .go           (go),
        .host_wr_fifo (host_wr_fifo),
        .host_rd_fifo (host_rd_fifo),
        .rsp_wr       (rsp_wr),
        .rsp_done     (rsp_done),
        .cmd_hdr_seen (cmd_hdr_seen),
        .cmd_target   (cmd_target),
        .rsp_hdr_seen (rsp_hdr_seen),
        .rsp_target   (rsp_target),
        .state        (cur_state),
        .wcnt         (wcnt),
        .rwcnt        (rwcnt),
        .rd_ptr       (rd_ptr),
        .rsp_len      (rsp_len),
        .cmd_push     (cmd_push),
        .rsp_push     (rsp_push),
        .go_ok        (go_ok),
        .expect_flag  (expect_flag),
        .avail_flag   (avail_flag),
        .burst        (burst)
    );

    cfe_len_tracker #(.DEPTH(DEPTH), .CW(CW)) u_cmd_len (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (abort),
        .push     (cmd_push),
        .idx      (wcnt),
        .byte_in  (bus_wdata),
        .hdr_seen (cmd_hdr_seen),
        .target   (cmd_target)
    );

    cfe_len_tracker #(.DEPTH(DEPTH), .CW(CW)) u_rsp_len (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (abort || go_ok),
        .push     (rsp_push),
        .idx      (rwcnt),
        .byte_in  (rsp_byte),
        .hdr_seen (rsp_hdr_seen),
        .target   (rsp_target)
    );

    // Single buffer write port: command bytes in reception, response in execution.
    always_comb begin
        st_wr_en   = cmd_push || rsp_push;
        st_wr_idx  = cmd_push ? wcnt[AW-1:0] : rwcnt[AW-1:0];
        st_wr_byte = cmd_push ? bus_wdata : rsp_byte;
    end

    cfe_byte_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk       (clk),
        .wr_en     (st_wr_en),
        .wr_idx    (st_wr_idx),
        .wr_byte   (st_wr_byte),
        .rd_a_idx  (cmd_rd_addr),
        .rd_a_byte (cmd_rd_data),
        .rd_b_idx  (rd_ptr[AW-1:0]),
        .rd_b_byte (host_byte)
    );

    // Host read data by offset.
    always_comb begin
        status_byte = 8'h00;
        status_byte[BIT_VALID]  = 1'b1;
        status_byte[BIT_READY]  = (cur_state == ST_READY);
        status_byte[BIT_AVAIL]  = avail_flag;
        status_byte[BIT_EXPECT] = expect_flag;
        case (bus_addr)
            OFS_STS:      bus_rdata = status_byte;
            OFS_BURST_LO: bus_rdata = burst[7:0];
            OFS_BURST_HI: bus_rdata = burst[15:8];
            OFS_FIFO:     bus_rdata = avail_flag ? host_byte : IDLE_BYTE;
            default:      bus_rdata = IDLE_BYTE;
        endcase
    end

    // Backend-facing outputs.
    always_comb begin
        exec_req = (cur_state == ST_EXEC);
        cmd_len  = wcnt;
    end

endmodule

// File: rtl/cfe_checker.sv
// Temporal checks on the FIFO engine, bound into the top module.
// Assumes the host never reads and writes in the same cycle.
module cfe_checker
    import cfe_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [7:0]    bus_addr,
    input logic [7:0]    bus_wdata,
    input logic [7:0]    bus_rdata,
    input logic          exec_req,
    input eng_state_t    state,
    input logic [CW-1:0] wcnt,
    input logic [CW-1:0] rd_ptr,
    input logic [CW-1:0] rsp_len
);

    assert_abort_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_STS && bus_wdata[BIT_READY])
        |=> (state == ST_READY && !exec_req));

    assert_go_needed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(exec_req) |-> $past(bus_wr && bus_addr == OFS_STS && bus_wdata[BIT_GO]));

    assert_wcnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wcnt <= CW'(DEPTH));

    assert_rdptr_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ptr <= rsp_len);

    assert_read_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == OFS_FIFO && state == ST_DONE && rd_ptr < rsp_len)
        |=> (rd_ptr == $past(rd_ptr) + CW'(1)));

    assert_idle_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFS_FIFO && state != ST_DONE) |-> (bus_rdata == IDLE_BYTE));

endmodule

bind cmd_rsp_fifo_engine cfe_checker #(.DEPTH(DEPTH), .CW(CW)) u_cfe_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .exec_req  (exec_req),
    .state     (cur_state),
    .wcnt      (wcnt),
    .rd_ptr    (rd_ptr),
    .rsp_len   (rsp_len)
);

// File: tb/test_cmd_rsp_fifo_engine.sv
module test_cmd_rsp_fifo_engine;

    localparam int DEPTH = 64;
    localparam int AW    = $clog2(DEPTH);
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]    bus_addr = 8'h00, bus_wdata = 8'h00;
    logic [7:0]    bus_rdata;
    logic          exec_req;
    logic [CW-1:0] cmd_len;
    logic [AW-1:0] cmd_rd_addr = '0;
    logic [7:0]    cmd_rd_data;
    logic          rsp_wr = 1'b0, rsp_done = 1'b0;
    logic [7:0]    rsp_byte = 8'h00;

    int nchk = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    cmd_rsp_fifo_engine #(.DEPTH(DEPTH)) i_cmd_rsp_fifo_engine (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .exec_req(exec_req), .cmd_len(cmd_len), .cmd_rd_addr(cmd_rd_addr),
        .cmd_rd_data(cmd_rd_data), .rsp_wr(rsp_wr), .rsp_byte(rsp_byte),
        .rsp_done(rsp_done)
    );

    function automatic int clampl(int d);
        if (d < 10) return 10;
        if (d > DEPTH) return DEPTH;
        return d;
    endfunction

    function automatic int rsp_eff(int decl, int nwr);
        int c;
        if (nwr < 6) return nwr;
        c = clampl(decl);
        return (c < nwr) ? c : nwr;
    endfunction

    function automatic logic [7:0] hdr_byte(int k, int decl, logic [7:0] fill);
        if (k >= 2 && k <= 5) return 8'((decl >> (8 * (5 - k))) & 255);
        return fill;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic read_sts(output logic [7:0] s, output int b);
        logic [7:0] lo, hi;
        bus_read(8'h18, s);
        bus_read(8'h19, lo);
        bus_read(8'h1A, hi);
        b = {hi, lo};
    endtask

    task automatic check_ready(input string req);
        logic [7:0] s;
        int b;
        read_sts(s, b);
        chk(s == 8'hC0, req, s, 8'hC0);
        chk(b == DEPTH, req, b, DEPTH);
        chk(exec_req == 1'b0, req, exec_req, 0);
    endtask

    // Full command/response exchange with checks at each step.
    task automatic run_txn(input int decl, input int rdecl, input int nwr);
        logic [7:0] cmd [DEPTH];
        logic [7:0] rsp [DEPTH];
        logic [7:0] s, v;
        int b, tgt, eff;
        tgt = clampl(decl);
        for (int k = 0; k < DEPTH; k++) begin
            cmd[k] = hdr_byte(k, decl, 8'($urandom));
            rsp[k] = hdr_byte(k, rdecl, 8'($urandom));
        end
        for (int i = 0; i < tgt; i++) begin
            bus_write(8'h24, cmd[i]);
            read_sts(s, b);
            chk(s[3] == (i + 1 < tgt), "R3 expect", s, i);
            chk(s[7] == 1'b1 && s[6] == 1'b0 && s[5] == 1'b0 && s[4] == 1'b0, "R2 bits", s, 8'h88);
            chk(b == DEPTH - (i + 1), "R4 burst recv", b, DEPTH - (i + 1));
        end
        bus_write(8'h24, 8'h5A);
        read_sts(s, b);
        chk(b == DEPTH - tgt, "R4 extra write", b, DEPTH - tgt);
        chk(s == 8'h80, "R3 complete", s, 8'h80);
        bus_write(8'h18, 8'h20);
        chk(exec_req == 1'b1, "R5 exec_req", exec_req, 1);
        chk(int'(cmd_len) == tgt, "R5 cmd_len", cmd_len, tgt);
        for (int i = 0; i < tgt; i++) begin
            @(negedge clk);
            cmd_rd_addr = AW'(i);
            #1 chk(cmd_rd_data == cmd[i], "R5 cmd byte", cmd_rd_data, cmd[i]);
        end
        bus_write(8'h24, 8'h11);
        bus_read(8'h24, v);
        chk(v == 8'hFF, "R8 fifo read in exec", v, 8'hFF);
        for (int i = 0; i < nwr; i++) begin
            @(negedge clk);
            rsp_wr = 1'b1; rsp_byte = rsp[i];
        end
        @(negedge clk);
        rsp_wr = 1'b0; rsp_done = 1'b1;
        @(negedge clk);
        rsp_done = 1'b0;
        eff = rsp_eff(rdecl, nwr);
        read_sts(s, b);
        chk(s == 8'h90, "R6 avail", s, 8'h90);
        chk(b == eff, "R6 burst", b, eff);
        chk(exec_req == 1'b0, "R6 exec drop", exec_req, 0);
        @(negedge clk);
        rsp_wr = 1'b1; rsp_byte = ~rsp[0];
        @(negedge clk);
        rsp_wr = 1'b0;
        bus_write(8'h24, 8'h33);
        read_sts(s, b);
        chk(b == eff, "R10 stray rsp_wr", b, eff);
        for (int i = 0; i < eff; i++) begin
            bus_read(8'h24, v);
            chk(v == rsp[i], "R7 rsp byte (R10 untouched)", v, rsp[i]);
            read_sts(s, b);
            chk(b == eff - i - 1, "R7 burst", b, eff - i - 1);
            chk(s[4] == (i + 1 < eff), "R7 avail", s, i);
        end
        bus_read(8'h24, v);
        chk(v == 8'hFF, "R8 drained read", v, 8'hFF);
        read_sts(s, b);
        chk(b == 0, "R8 drained burst", b, 0);
        bus_write(8'h18, 8'h40);
        check_ready("R9 abort after done");
    endtask

    initial begin
        logic [7:0] s, v;
        int b;
        void'($urandom(32'd20250607));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check_ready("R1 reset");
        bus_read(8'h24, v);
        chk(v == 8'hFF, "R1 fifo read", v, 8'hFF);
        bus_read(8'h30, v);
        chk(v == 8'hFF, "R2 unmapped", v, 8'hFF);

        // R10 response strobe in ready state
        @(negedge clk);
        rsp_wr = 1'b1; rsp_byte = 8'h77;
        @(negedge clk);
        rsp_wr = 1'b0;
        check_ready("R10 rsp_wr in ready");

        // R5 go on incomplete command, then R9 abort in reception
        for (int i = 0; i < 4; i++) bus_write(8'h24, 8'(i));
        bus_write(8'h18, 8'h20);
        chk(exec_req == 1'b0, "R5 early go", exec_req, 0);
        read_sts(s, b);
        chk(s == 8'h88, "R5 expect held", s, 8'h88);
        bus_write(8'h18, 8'h40);
        check_ready("R9 abort recv");

        // R9 abort and go together
        for (int i = 0; i < 10; i++) bus_write(8'h24, hdr_byte(i, 10, 8'hA5));
        bus_write(8'h18, 8'h60);
        chk(exec_req == 1'b0, "R9 abort beats go", exec_req, 0);
        check_ready("R9 combined write");

        // R9 abort during execution
        for (int i = 0; i < 12; i++) bus_write(8'h24, hdr_byte(i, 12, 8'h3C));
        bus_write(8'h18, 8'h20);
        chk(exec_req == 1'b1, "R5 go complete", exec_req, 1);
        bus_write(8'h18, 8'h40);
        check_ready("R9 abort exec");

        // R3 clamp corners and R6 short responses, then random mix
        run_txn(5, 3, 40);
        run_txn(300, 500, DEPTH);
        run_txn(DEPTH, 20, 4);
        for (int t = 0; t < 20; t++) begin
            int d, rd, nw;
            d  = ($urandom_range(0, 7) == 0) ? $urandom_range(0, 200) : $urandom_range(10, DEPTH);
            rd = ($urandom_range(0, 7) == 0) ? $urandom_range(0, 200) : $urandom_range(10, DEPTH);
            nw = $urandom_range(1, DEPTH);
            run_txn(d, rd, nw);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule